// File: doc/BRIEF.md
# Register Write-Protection Gate

This block sits on the bus side of a peripheral's register space and decides, for each write, whether it may proceed. Every byte of the protected space has its own lock bit. A locked byte refuses writes until the lock is cleared. A single configuration word can freeze all lock bits until the next reset, and it can also open the protected space to masters that are not privileged. The peripheral's registers are modelled here by a small internal register file of `NUM_REGS` 32-bit words.

The bus presents a word address, four byte enables, write data and a privilege flag with a one-cycle request. One cycle later the gate answers with an acknowledge, an optional transfer-error flag and read data. Byte offsets below are the word address times four.

The space has four windows. The direct window starts at byte 0x0000. The mirror window starts at 0x2000: a write there updates the same register and also locks each byte it writes. The lock window starts at 0x3800. The configuration word is at 0x3FFC.

Top module: `regprot_gate`

## Requirements
- R1: After reset the gate holds ack and err low, every lock bit reads as 0, the configuration word reads as 0, and all registers read as 0.
- R2: A privileged write to the direct window (byte offsets 0x0000–0x17FF, word w at 4w) with no locked enabled lane updates exactly the enabled bytes of register w. Every request is answered by ack high in the next cycle. When err is high it is high in that same cycle and only for that one cycle.
- R3: A write at byte offset 0x2000+4w updates register w like a direct write. While the freeze bit is clear, it also sets the lock bit of every enabled lane. A read there returns register w.
- R4: A write to the direct or mirror window whose enabled lanes include any locked byte returns err and changes no byte of the register, not even the unlocked ones.
- R5: Lock register n is byte 0x3800+n, and its bit k locks byte k of word n. On a write, each enabled lane byte carries four update enables in bits 7:4 and four new lock values in bits 3:0. Only the lock bits whose paired enable is 1 change. A read returns the lock values in bits 3:0 of each lane, with bits 7:4 reading 0.
- R6: Configuration bit 1 (freeze) is set by writing 1 and can be cleared only by reset. While it is set, lock-window writes and mirror writes leave every lock bit unchanged, but mirror writes still update the register.
- R7: The configuration word at 0x3FFC holds user access in bit 0 and freeze in bit 1; the other bits read 0. A write with lane 0 enabled loads bit 0 and can only set bit 1.
- R8: A request with the privilege flag low returns err and has no effect if user access is 0. A request with the privilege flag low that addresses the configuration word always returns err.
- R9: A lock-window request that enables a lane whose lock register does not exist returns err. So does any request in 0x3E00–0x3FFB.
- R10: Reads never change lock bits or registers.
- R11: Direct or mirror words at or above `NUM_REGS`, and the span 0x1800–0x1FFF, read as 0 and ignore writes without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per transfer |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | 1 = privileged master, 0 = user-mode master |
| addr_i | input | 12 | Word address (byte offset bits 13:2) |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Transfer answered, one cycle after the request |
| err_o | output | 1 | Transfer error, valid with ack_o |
| rdata_o | output | 32 | Read data, valid with ack_o; 0 on an error |

## Verification
A lock bit that is wrongly set shows up at the next write to that byte, which returns err and leaves the register unchanged. A lock bit that is wrongly clear lets such a write through. Either kind of corruption can also be read straight from the lock window one cycle after the request that caused it. The bench keeps its own model of the registers, locks and configuration, and compares ack, err and read data after every request and on the idle cycle that follows. A wrong freeze or user-access bit therefore surfaces on the first access that depends on it.

// File: rtl/regprot_pkg.sv
package regprot_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int WADDR_W = 12;

    // Window boundaries as word addresses (byte offset / 4)
    localparam logic [WADDR_W-1:0] RSVD_WBASE   = 12'h600;
    localparam logic [WADDR_W-1:0] MIRROR_WBASE = 12'h800;
    localparam logic [WADDR_W-1:0] LOCK_WBASE   = 12'hE00;
    localparam logic [WADDR_W-1:0] LOCK_WEND    = 12'hF80;
    localparam logic [WADDR_W-1:0] CFG_WADDR    = 12'hFFF;

    typedef enum logic [2:0] {
        RG_DIRECT,
        RG_RSVD,
        RG_MIRROR,
        RG_LOCK,
        RG_CFG,
        RG_BAD
    } region_e;

    typedef struct packed {
        logic freeze;
        logic user_ok;
    } cfg_t;

endpackage

// File: rtl/regprot_decode.sv
module regprot_decode
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic [WADDR_W-1:0] addr_i,
    output region_e            region_o,
    output logic [IDX_W-1:0]   word_o,
    output logic               word_ok_o,
    output logic [IDX_W-1:0]   lock_base_o,
    output logic [LANES-1:0]   lane_ok_o
);

    localparam int CNT_W = WADDR_W + 2;
    localparam logic [CNT_W-1:0] NR_C = CNT_W'(NUM_REGS);

    logic [WADDR_W-1:0] word_off;
    logic [WADDR_W-1:0] lock_off;
    logic [CNT_W-1:0]   lock_first;

    always_comb begin
        region_o = RG_BAD;
        word_off = '0;
        lock_off = '0;
        if (addr_i < RSVD_WBASE) begin
            region_o = RG_DIRECT;
            word_off = addr_i;
        end else if (addr_i < MIRROR_WBASE) begin
            region_o = RG_RSVD;
        end else if (addr_i < LOCK_WBASE) begin
            region_o = RG_MIRROR;
            word_off = addr_i - MIRROR_WBASE;
        end else if (addr_i < LOCK_WEND) begin
            region_o = RG_LOCK;
            lock_off = addr_i - LOCK_WBASE;
        end else if (addr_i == CFG_WADDR) begin
            region_o = RG_CFG;
        end
    end

    assign word_ok_o   = {2'b00, word_off} < NR_C;
    assign word_o      = word_off[IDX_W-1:0];
    assign lock_first  = {lock_off, 2'b00};
    assign lock_base_o = lock_first[IDX_W-1:0];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_ok_o[j] = (lock_first + CNT_W'(j)) < NR_C;
    end

endmodule

// File: rtl/regprot_regfile.sv
module regprot_regfile
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            for (int j = 0; j < LANES; j++) begin
                if (be_i[j]) begin
                    regs_d[idx_i][8*j +: 8] = wdata_i[8*j +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = regs_q[idx_i];

endmodule

// File: rtl/regprot_lockbank.sv
module regprot_lockbank
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       freeze_i,
    input  logic [IDX_W-1:0]           chk_idx_i,
    output logic [LANES-1:0]           chk_o,
    input  logic [IDX_W-1:0]           base_i,
    output logic [LANES-1:0][LANES-1:0] win_o,
    input  logic                       set_i,
    input  logic [LANES-1:0]           set_mask_i,
    input  logic                       upd_i,
    input  logic [LANES-1:0]           upd_be_i,
    input  logic [DATA_W-1:0]          upd_data_i
);

    logic [NUM_REGS-1:0][LANES-1:0] lk_d, lk_q;
    logic [LANES-1:0][IDX_W-1:0]    lane_idx;

    for (genvar j = 0; j < LANES; j++) begin : g_win
        assign lane_idx[j] = base_i + IDX_W'(j);
        assign win_o[j]    = lk_q[lane_idx[j]];
    end

    assign chk_o = lk_q[chk_idx_i];

    always_comb begin
        lk_d = lk_q;
        if (set_i) begin
            lk_d[chk_idx_i] = lk_q[chk_idx_i] | set_mask_i;
        end
        if (upd_i) begin
            for (int j = 0; j < LANES; j++) begin
                if (upd_be_i[j]) begin
                    for (int k = 0; k < LANES; k++) begin
                        if (upd_data_i[8*j + 4 + k]) begin
                            lk_d[lane_idx[j]][k] = upd_data_i[8*j + k];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    AST_LOCKS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(lk_q)); // R6

endmodule

// File: rtl/regprot_gate.sv
module regprot_gate
    import regprot_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               we_i,
    input  logic               priv_i,
    input  logic [WADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]   be_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               ack_o,
    output logic               err_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
        cfg_t              cfg;
    } gate_st_t;

    gate_st_t st_d, st_q;

    region_e                     region;
    logic [IDX_W-1:0]            word_idx;
    logic                        word_ok;
    logic [IDX_W-1:0]            lock_base;
    logic [LANES-1:0]            lane_ok;
    logic [LANES-1:0]            chk_nib;
    logic [LANES-1:0][LANES-1:0] win_nib;
    logic [DATA_W-1:0]           rf_rdata;

    logic bad, deny, hit, locked;
    logic rf_wr, set_en, upd_en;

    regprot_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_decode (
        .addr_i      (addr_i),
        .region_o    (region),
        .word_o      (word_idx),
        .word_ok_o   (word_ok),
        .lock_base_o (lock_base),
        .lane_ok_o   (lane_ok)
    );

    regprot_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (rf_wr),
        .idx_i   (word_idx),
        .be_i    (be_i),
        .wdata_i (wdata_i),
        .rdata_o (rf_rdata)
    );

    regprot_lockbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze_i   (st_q.cfg.freeze),
        .chk_idx_i  (word_idx),
        .chk_o      (chk_nib),
        .base_i     (lock_base),
        .win_o      (win_nib),
        .set_i      (set_en),
        .set_mask_i (be_i),
        .upd_i      (upd_en),
        .upd_be_i   (be_i),
        .upd_data_i (wdata_i)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ack   = req_i;
        st_d.err   = 1'b0;
        st_d.rdata = '0;
        rf_wr      = 1'b0;
        set_en     = 1'b0;
        upd_en     = 1'b0;

        bad    = (region == RG_BAD) || ((region == RG_LOCK) && |(be_i & ~lane_ok));
        deny   = !priv_i && ((region == RG_CFG) || !st_q.cfg.user_ok);
        hit    = ((region == RG_DIRECT) || (region == RG_MIRROR)) && word_ok;
        locked = we_i && hit && |(be_i & chk_nib);

        if (req_i) begin
            if (bad || deny || locked) begin
                st_d.err = 1'b1;
            end else begin
                unique case (region)
                    RG_DIRECT, RG_MIRROR: begin
                        if (hit) begin
                            if (we_i) begin
                                rf_wr  = 1'b1;
                                set_en = (region == RG_MIRROR) && !st_q.cfg.freeze;
                            end else begin
                                st_d.rdata = rf_rdata;
                            end
                        end
                    end
                    RG_LOCK: begin
                        if (we_i) begin
                            upd_en = !st_q.cfg.freeze;
                        end else begin
                            for (int j = 0; j < LANES; j++) begin
                                st_d.rdata[8*j +: 8] = lane_ok[j] ? 8'(win_nib[j]) : 8'h00;
                            end
                        end
                    end
                    RG_CFG: begin
                        if (we_i) begin
                            if (be_i[0]) begin
                                st_d.cfg.user_ok = wdata_i[0];
                                st_d.cfg.freeze  = st_q.cfg.freeze | wdata_i[1];
                            end
                        end else begin
                            st_d.rdata = DATA_W'({st_q.cfg.freeze, st_q.cfg.user_ok});
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o   = st_q.ack;
    assign err_o   = st_q.err;
    assign rdata_o = st_q.rdata;

    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ack_o); // R2

    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.freeze |=> st_q.cfg.freeze); // R6

    AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !priv_i && !st_q.cfg.user_ok) |=> err_o); // R8

    AST_LOCKED_WRITE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && word_ok && |(be_i & chk_nib) &&
         ((region == RG_DIRECT) || (region == RG_MIRROR))) |=> err_o); // R4

    AST_CFG_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && region == RG_CFG && priv_i) |=> (rdata_o[DATA_W-1:2] == '0)); // R7

endmodule

// File: tb/tb_regprot_gate.sv
module tb_regprot_gate;

    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic        priv = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wd = '0;
    logic        ack, err;
    logic [31:0] rdata;

    always #5 clk = ~clk;

    regprot_gate #(.NUM_REGS(NR)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .we_i    (we),
        .priv_i  (priv),
        .addr_i  (addr),
        .be_i    (be),
        .wdata_i (wd),
        .ack_o   (ack),
        .err_o   (err),
        .rdata_o (rdata)
    );

    logic [31:0] m_reg [NR];
    logic [3:0]  m_lk  [NR];
    bit          m_user, m_frz;
    int          n_cmp = 0;
    int          n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            m_reg[i] = '0;
            m_lk[i]  = '0;
        end
        m_user = 0;
        m_frz  = 0;
    endtask

    task automatic apply_reset();
        req   = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ack low in reset", {31'b0, ack}, 32'd0);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R1 ack low after reset", {31'b0, ack}, 32'd0);
        chk("R1 err low after reset", {31'b0, err}, 32'd0);
    endtask

    // One transfer: the model predicts, the design is driven, outputs compared
    task automatic xfer(input bit w, input int ba, input logic [3:0] b,
                        input logic [31:0] d, input bit p, input string tag);
        int a;
        int wi;
        int n;
        bit e;
        logic [31:0] r;
        a = ba & 'h3FFC;
        e = 0;
        r = '0;
        if (a >= 'h3E00 && a != 'h3FFC) e = 1;
        if (a >= 'h3800 && a < 'h3E00)
            for (int j = 0; j < 4; j++) if (b[j] && (a - 'h3800 + j) >= NR) e = 1;
        if (!e && !p && (a == 'h3FFC || !m_user)) e = 1;
        if (!e) begin
            if (a < 'h1800 || (a >= 'h2000 && a < 'h3800)) begin
                wi = (a < 'h1800) ? a / 4 : (a - 'h2000) / 4;
                if (wi < NR) begin
                    if (w) begin
                        for (int j = 0; j < 4; j++) if (b[j] && m_lk[wi][j]) e = 1;
                        if (!e) begin
                            for (int j = 0; j < 4; j++) begin
                                if (b[j]) begin
                                    m_reg[wi][8*j +: 8] = d[8*j +: 8];
                                    if (a >= 'h2000 && !m_frz) m_lk[wi][j] = 1'b1;
                                end
                            end
                        end
                    end else begin
                        r = m_reg[wi];
                    end
                end
            end else if (a >= 'h3800 && a < 'h3E00) begin
                for (int j = 0; j < 4; j++) begin
                    n = a - 'h3800 + j;
                    if (n < NR) begin
                        if (w) begin
                            if (b[j] && !m_frz)
                                for (int k = 0; k < 4; k++)
                                    if (d[8*j + 4 + k]) m_lk[n][k] = d[8*j + k];
                        end else begin
                            r[8*j +: 4] = m_lk[n];
                        end
                    end
                end
            end else if (a == 'h3FFC) begin
                if (w) begin
                    if (b[0]) begin
                        m_user = d[0];
                        if (d[1]) m_frz = 1;
                    end
                end else begin
                    r = {30'b0, m_frz, m_user};
                end
            end
        end
        if (e) r = '0;

        req  = 1'b1;
        we   = w;
        addr = a[13:2];
        be   = b;
        wd   = d;
        priv = p;
        @(negedge clk);
        chk({tag, " ack"}, {31'b0, ack}, 32'd1);
        chk({tag, " err"}, {31'b0, err}, {31'b0, e});
        chk({tag, " rdata"}, rdata, r);
        req = 1'b0;
        we  = 1'b0;
        @(negedge clk);
        chk({tag, " R2 idle ack"}, {31'b0, ack}, 32'd0);
        chk({tag, " R2 idle err"}, {31'b0, err}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        apply_reset();
        xfer(0, 'h3FFC, 4'hF, 0, 1, "R1 cfg reads zero");
        xfer(0, 'h3800, 4'hF, 0, 1, "R1 locks clear");
        xfer(0, 'h0010, 4'hF, 0, 1, "R1 register clear");

        xfer(1, 'h0000, 4'hF, 32'hA1B2C3D4, 1, "R2 full write");
        xfer(0, 'h0000, 4'hF, 0, 1, "R2 full readback");
        xfer(1, 'h0004, 4'b0101, 32'h11223344, 1, "R2 partial write");
        xfer(0, 'h0004, 4'hF, 0, 1, "R2 partial readback");

        xfer(1, 'h2008, 4'b0011, 32'hCAFEF00D, 1, "R3 mirror write");
        xfer(0, 'h2008, 4'hF, 0, 1, "R3 mirror read");
        xfer(0, 'h3800, 4'hF, 0, 1, "R3 locks set by mirror");
        xfer(1, 'h0008, 4'b0100, 32'h00770000, 1, "R3 unlocked lane writable");
        xfer(1, 'h0008, 4'b0001, 32'h000000EE, 1, "R4 locked lane");
        xfer(1, 'h0008, 4'hF, 32'h55555555, 1, "R4 mixed lanes");
        xfer(1, 'h2008, 4'b1001, 32'h99000099, 1, "R4 mirror onto lock");
        xfer(0, 'h0008, 4'hF, 0, 1, "R4 register unchanged");

        xfer(1, 'h3800, 4'b0001, 32'h00000031, 1, "R5 masked lock set");
        xfer(1, 'h0000, 4'b0010, 32'h00004400, 1, "R5 unlocked lane ok");
        xfer(1, 'h0000, 4'b0001, 32'h00000044, 1, "R5 locked lane fails");
        xfer(1, 'h3800, 4'b0100, 32'h00100000, 1, "R5 clear one bit");
        xfer(0, 'h3800, 4'hF, 0, 1, "R5 lock readback");
        xfer(1, 'h0008, 4'b0001, 32'h00000012, 1, "R5 cleared lane writable");

        xfer(0, 'h2008, 4'hF, 0, 1, "R10 mirror read");
        xfer(0, 'h0000, 4'hF, 0, 1, "R10 direct read");
        xfer(0, 'h3800, 4'hF, 0, 1, "R10 locks unchanged");

        xfer(0, 'h3810, 4'hF, 0, 1, "R9 missing lock register");
        xfer(0, 'h3810, 4'b0000, 0, 1, "R9 no lane enabled");
        xfer(1, 'h3E00, 4'hF, 32'hFFFFFFFF, 1, "R9 gap start");
        xfer(0, 'h3FF8, 4'hF, 0, 1, "R9 gap below cfg");

        xfer(1, 'h0040, 4'hF, 32'h12345678, 1, "R11 word beyond range");
        xfer(0, 'h0040, 4'hF, 0, 1, "R11 beyond reads zero");
        xfer(1, 'h1800, 4'hF, 32'h12345678, 1, "R11 reserved span");
        xfer(0, 'h1800, 4'hF, 0, 1, "R11 reserved reads zero");

        xfer(1, 'h000C, 4'hF, 32'hDEADBEEF, 0, "R8 user write blocked");
        xfer(0, 'h000C, 4'hF, 0, 1, "R8 blocked write no effect");
        xfer(0, 'h3FFC, 4'hF, 0, 0, "R8 user cfg read");
        xfer(1, 'h3FFC, 4'b0001, 32'h1, 1, "R7 enable user access");
        xfer(0, 'h3FFC, 4'hF, 0, 1, "R7 cfg readback");
        xfer(1, 'h000C, 4'hF, 32'hDEADBEEF, 0, "R8 user write allowed");
        xfer(0, 'h000C, 4'hF, 0, 0, "R8 user read allowed");
        xfer(1, 'h3FFC, 4'b0001, 32'h0, 0, "R8 user cfg write");
        xfer(1, 'h3FFC, 4'b1110, 32'h0, 1, "R7 lane0 disabled");

        xfer(1, 'h3FFC, 4'b0001, 32'h3, 1, "R6 set freeze");
        xfer(1, 'h3804, 4'hF, 32'hFFFFFFFF, 1, "R6 lock write frozen");
        xfer(0, 'h3804, 4'hF, 0, 1, "R6 locks held");
        xfer(1, 'h2014, 4'hF, 32'h0BADCAFE, 1, "R6 mirror writes register");
        xfer(0, 'h0014, 4'hF, 0, 1, "R6 register updated");
        xfer(0, 'h3804, 4'hF, 0, 1, "R6 no lock from mirror");
        xfer(1, 'h3FFC, 4'b0001, 32'h1, 1, "R6 freeze not clearable");
        xfer(0, 'h3FFC, 4'hF, 0, 1, "R6 freeze still set");
        apply_reset();
        xfer(0, 'h3FFC, 4'hF, 0, 1, "R6 reset clears cfg");

        for (int it = 0; it < 600; it++) begin
            int sel;
            int ba;
            bit w;
            logic [31:0] d;
            sel = $urandom_range(0, 9);
            d   = $urandom();
            w   = $urandom_range(0, 1) == 1;
            case (sel)
                0, 1, 2: ba = 4 * $urandom_range(0, NR + 1);
                3, 4:    ba = 'h2000 + 4 * $urandom_range(0, NR + 1);
                5, 6:    ba = 'h3800 + 4 * $urandom_range(0, NR / 4);
                7:       ba = 'h3FFC;
                8:       ba = 'h3E00 + 4 * $urandom_range(0, 126);
                default: ba = 'h1800 + 4 * $urandom_range(0, 511);
            endcase
            if (ba == 'h3FFC && $urandom_range(0, 3) != 0) d = d & 32'h1;
            if ((it % 150) == 149) apply_reset();
            xfer(w, ba, 4'($urandom_range(0, 15)), d, $urandom_range(0, 3) != 0,
                 "R2 R4 R5 random mix");
        end

        summary();
    end

endmodule